// File: doc/BRIEF.md
# Cell Bus Receive Controller (16-bit)

This block sits on the ATM-layer side of a 16-bit cell bus and pulls whole cells out of a single physical-layer device. It holds the read enable high while the device reports that a cell is ready and the downstream cell buffer has room. It takes one word on each cycle that follows a cycle with the enable high. It locks onto cell boundaries using the start-of-cell marker that comes with the first word of every cell.

Each cell is 27 words long. From the first two words the block decodes the 12-bit path identifier, the 16-bit channel identifier and the cell-loss-priority bit, and presents them with a one-cycle strobe so that the switch can begin its translation lookup at once. The third word carries the header check byte and a spare byte, and it is dropped. The 24 payload words go out on a buffer write port, each with its index in the payload. Every word is checked for odd parity. A cell that contained a bad word is marked for discard on its end-of-cell strobe. A start-of-cell marker that arrives in the middle of a cell throws away the partial cell.

Top module: `cell_rx16`

## Requirements
- R1: `rd_en` is a combinational output that is high exactly when reset is released, `phy_avail` is high and `buf_full` is low. No word is therefore taken in the cycle after one in which `buf_full` was high.
- R2: A bus word is taken only at the clock edge that ends a cycle whose previous cycle had `rd_en` high. The bus is ignored at every other edge, whatever its start marker, data or parity. Any output strobe caused by a word appears in the cycle after that word is taken, which is two cycles after the enable cycle.
- R3: Outside a cell (after reset or after a complete cell), words taken with `rx_soc` low are ignored.
- R4: A cell is 27 words. The word taken with `rx_soc` high is word 0. When word 26 is taken, `cell_end` pulses for one cycle, in the same cycle as the last payload write. The block then waits for a new start marker.
- R5: Header decode takes the path identifier from word0[15:4], the channel identifier from {word0[3:0], word1[15:4]}, and the priority bit from word1[0]. `hdr_valid` pulses for one cycle in the cycle after word 1 is taken, with the three fields valid in that cycle.
- R6: Word 2 produces no output. Words 3 to 26 are written out with `pay_we` high, carrying `pay_data` and `pay_idx` 0 to 23 in order.
- R7: A word passes parity when its 16 data bits and `rx_par` together hold an odd number of ones. If any word of a cell fails, `cell_bad` is high together with that cell's `cell_end`. The error flag clears at the next start marker.
- R8: A start marker taken while a cell is in progress pulses `cell_abort`, and no `cell_end` is given for the partial cell. The marked word becomes word 0 of a new cell.
- R9: During reset `rd_en` is low and every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_avail | input | 1 | Device reports a cell ready to transfer |
| buf_full | input | 1 | Downstream cell buffer cannot accept more words |
| rx_data | input | 16 | Bus data word |
| rx_soc | input | 1 | Start-of-cell marker for the first word |
| rx_par | input | 1 | Odd parity bit over `rx_data` |
| rd_en | output | 1 | Read enable to the device |
| hdr_valid | output | 1 | One-cycle strobe for the decoded header fields |
| hdr_vpi | output | 12 | Path identifier |
| hdr_vci | output | 16 | Channel identifier |
| hdr_clp | output | 1 | Cell loss priority bit |
| pay_we | output | 1 | Payload word write strobe |
| pay_data | output | 16 | Payload word |
| pay_idx | output | 5 | Payload word index, 0 to 23 |
| cell_end | output | 1 | Last word of a complete cell was taken |
| cell_bad | output | 1 | With `cell_end`: the cell had a parity error |
| cell_abort | output | 1 | Partial cell discarded on an early start marker |

## Verification
A word counter that is off by one shows up within the same cell. The header strobe lands on the wrong word, payload indices shift, and `cell_end` comes one word early or late, so the error is visible at most 27 taken words after the fault. A sticky error flag that fails to clear, or fails to set, shows up on the very next `cell_end`. A word taken on the wrong cycle relative to `rd_en` either adds a stray strobe or moves every later strobe, and the first following header or payload event exposes it. The bench compares the complete ordered stream of output events against one built from the generated cells, so a single misplaced word is caught.

// File: rtl/cell_rx16.sv
module cell_rx16 #(
  parameter int CELL_WORDS = 27,
  parameter int HDR_WORDS  = 3,
  parameter int PIW        = $clog2(CELL_WORDS - HDR_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           phy_avail,
  input  logic           buf_full,
  input  logic [15:0]    rx_data,
  input  logic           rx_soc,
  input  logic           rx_par,
  output logic           rd_en,
  output logic           hdr_valid,
  output logic [11:0]    hdr_vpi,
  output logic [15:0]    hdr_vci,
  output logic           hdr_clp,
  output logic           pay_we,
  output logic [15:0]    pay_data,
  output logic [PIW-1:0] pay_idx,
  output logic           cell_end,
  output logic           cell_bad,
  output logic           cell_abort
);
  localparam int CW = $clog2(CELL_WORDS);
  localparam logic [CW-1:0] LAST = CW'(CELL_WORDS - 1);
  localparam logic [CW-1:0] FIRST_PAY = CW'(HDR_WORDS);

  logic          take_q;
  logic [CW-1:0] cnt;
  logic          err;
  logic [15:0]   w0;

  wire perr   = ~^{rx_par, rx_data};
  wire in_cel = (cnt != '0);
  wire last   = (cnt == LAST);

  assign rd_en = rst_n & phy_avail & ~buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q     <= 1'b0;
      cnt        <= '0;
      err        <= 1'b0;
      w0         <= '0;
      hdr_valid  <= 1'b0;
      hdr_vpi    <= '0;
      hdr_vci    <= '0;
      hdr_clp    <= 1'b0;
      pay_we     <= 1'b0;
      pay_data   <= '0;
      pay_idx    <= '0;
      cell_end   <= 1'b0;
      cell_bad   <= 1'b0;
      cell_abort <= 1'b0;
    end else begin
      take_q     <= rd_en;
      hdr_valid  <= 1'b0;
      pay_we     <= 1'b0;
      cell_end   <= 1'b0;
      cell_bad   <= 1'b0;
      cell_abort <= 1'b0;
      if (take_q) begin
        if (rx_soc) begin
          cell_abort <= in_cel;
          cnt        <= CW'(1);
          err        <= perr;
          w0         <= rx_data;
        end else if (in_cel) begin
          err <= err | perr;
          cnt <= last ? '0 : cnt + CW'(1);
          if (cnt == CW'(1)) begin
            hdr_valid <= 1'b1;
            hdr_vpi   <= w0[15:4];
            hdr_vci   <= {w0[3:0], rx_data[15:4]};
            hdr_clp   <= rx_data[0];
          end
          if (cnt >= FIRST_PAY) begin
            pay_we   <= 1'b1;
            pay_data <= rx_data;
            pay_idx  <= PIW'(cnt - FIRST_PAY);
          end
          if (last) begin
            cell_end <= 1'b1;
            cell_bad <= err | perr;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cell_rx16_chk.sv
module cell_rx16_chk #(
  parameter int PIW       = 5,
  parameter int PAY_WORDS = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_en,
  input logic           buf_full,
  input logic           hdr_valid,
  input logic           pay_we,
  input logic [PIW-1:0] pay_idx,
  input logic           cell_end,
  input logic           cell_bad,
  input logic           cell_abort
);
  // R1
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_we |-> !$past(buf_full, 2));

  // R2
  enable_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_we || hdr_valid || cell_end || cell_abort) |-> $past(rd_en, 2));

  // R5
  hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R4
  end_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |-> (pay_we && pay_idx == PIW'(PAY_WORDS - 1)));

  // R7
  bad_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_bad |-> cell_end);

  // R8
  abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_abort |-> !cell_end);

  // R6
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_valid, pay_we, cell_abort}));
endmodule

bind cell_rx16 cell_rx16_chk #(.PIW(PIW), .PAY_WORDS(CELL_WORDS - HDR_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .buf_full(buf_full),
  .hdr_valid(hdr_valid), .pay_we(pay_we), .pay_idx(pay_idx),
  .cell_end(cell_end), .cell_bad(cell_bad), .cell_abort(cell_abort)
);

// File: tb/cell_rx16_test.sv
module cell_rx16_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic rst_n, phy_avail, buf_full, rx_soc, rx_par;
  logic [15:0] rx_data;
  logic rd_en, hdr_valid, hdr_clp, pay_we, cell_end, cell_bad, cell_abort;
  logic [11:0] hdr_vpi;
  logic [15:0] hdr_vci, pay_data;
  logic [4:0] pay_idx;

  cell_rx16 uut (
    .clk(clk), .rst_n(rst_n), .phy_avail(phy_avail), .buf_full(buf_full),
    .rx_data(rx_data), .rx_soc(rx_soc), .rx_par(rx_par), .rd_en(rd_en),
    .hdr_valid(hdr_valid), .hdr_vpi(hdr_vpi), .hdr_vci(hdr_vci), .hdr_clp(hdr_clp),
    .pay_we(pay_we), .pay_data(pay_data), .pay_idx(pay_idx),
    .cell_end(cell_end), .cell_bad(cell_bad), .cell_abort(cell_abort)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [17:0] strm [0:2047];
  int slen = 0;
  logic [47:0] expq [$];
  logic [47:0] obsq [$];

  task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic odd_par(logic [15:0] d);
    return ~^d;
  endfunction

  task automatic put(logic [15:0] d, logic soc, logic flip);
    strm[slen] = {soc, odd_par(d) ^ flip, d};
    slen++;
  endtask

  task automatic add_junk(int n);
    for (int i = 0; i < n; i++) put(16'($urandom), 1'b0, 1'($urandom));
  endtask

  task automatic add_cell(int len, int errpos);
    logic [15:0] w [27];
    logic bad;
    for (int i = 0; i < 27; i++) w[i] = 16'($urandom);
    for (int i = 0; i < len; i++) put(w[i], i == 0, i == errpos);
    if (len >= 2)
      expq.push_back({4'd1, 15'd0, w[0][15:4], w[0][3:0], w[1][15:4], w[1][0]});
    for (int i = 3; i < len; i++) expq.push_back({4'd2, 23'd0, 5'(i - 3), w[i]});
    bad = (errpos >= 0) && (errpos < len);
    if (len == 27) expq.push_back({4'd3, 43'd0, bad});
    else expq.push_back({4'd4, 44'd0});
  endtask

  task automatic build();
    add_junk(2);
    add_cell(27, -1);
    add_cell(27, 0);
    add_cell(27, 26);
    add_cell(27, -1);
    add_cell(1, -1);
    add_cell(2, -1);
    add_cell(26, 5);
    add_cell(27, -1);
    add_junk(3);
    add_cell(3, -1);
    add_cell(27, 13);
    for (int k = 0; k < 30; k++) begin
      int len, ep;
      len = ($urandom % 6 == 0) ? 1 + int'($urandom % 26) : 27;
      ep = ($urandom % 4 == 0) ? int'($urandom % 27) : -1;
      add_cell(len, ep);
      if (len == 27) add_junk(int'($urandom % 3));
    end
    add_cell(27, -1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (cell_abort) obsq.push_back({4'd4, 44'd0});
        if (hdr_valid) obsq.push_back({4'd1, 15'd0, hdr_vpi, hdr_vci, hdr_clp});
        if (pay_we) obsq.push_back({4'd2, 23'd0, pay_idx, pay_data});
        if (cell_end) obsq.push_back({4'd3, 43'd0, cell_bad});
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit req;
    int idx;
    int n;
    string tag;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    phy_avail = 1'b1;
    buf_full = 1'b0;
    rx_data = 16'hFFFF;
    rx_soc = 1'b1;
    rx_par = 1'b0;
    build();
    repeat (3) @(negedge clk);
    #1;
    chk(rd_en == 1'b0, "R9 rd_en held low in reset", {47'd0, rd_en}, 48'd0);
    chk({hdr_valid, pay_we, cell_end, cell_bad, cell_abort} == 5'd0,
        "R9 strobes low in reset",
        {43'd0, hdr_valid, pay_we, cell_end, cell_bad, cell_abort}, 48'd0);
    @(negedge clk);
    rst_n = 1'b1;
    phy_avail = 1'b0;
    req = 1'b0;
    idx = 0;
    @(posedge clk);
    while (idx < slen) begin
      @(negedge clk);
      if (req) begin
        {rx_soc, rx_par, rx_data} = strm[idx];
        idx++;
      end else begin
        rx_data = 16'($urandom);
        rx_soc = 1'($urandom);
        rx_par = 1'($urandom);
      end
      phy_avail = (idx < slen) && ($urandom % 6 != 0);
      buf_full = ($urandom % 7 == 0);
      #1;
      chk(rd_en == (phy_avail && !buf_full), "R1 read enable from avail and full",
          {47'd0, rd_en}, {47'd0, phy_avail && !buf_full});
      @(posedge clk);
      req = rd_en;
    end
    phy_avail = 1'b0;
    repeat (10) @(negedge clk);
    chk(obsq.size() == expq.size(), "R2 R3 output event count",
        48'(obsq.size()), 48'(expq.size()));
    n = (obsq.size() < expq.size()) ? obsq.size() : expq.size();
    for (int i = 0; i < n; i++) begin
      case (expq[i][47:44])
        4'd1: tag = "R5 header fields";
        4'd2: tag = "R6 payload word";
        4'd3: tag = "R4 R7 end of cell";
        default: tag = "R8 partial cell abort";
      endcase
      chk(obsq[i] == expq[i], tag, obsq[i], expq[i]);
    end
    finish_run();
  end
endmodule